// File: doc/BRIEF.md
# Serial Converter Front End with Address Decode and Conversion Sequencer

This block is the digital side of a serial-I/O analog-to-digital converter. A host drives chip select, a serial clock and a data-in line. While chip select is low, the host clocks in a five-bit address word on rising serial-clock edges. The word carries a power flag, an input-mode flag and a three-bit channel selector. The block decodes the word into multiplexer controls. It then holds the selected positive input in acquisition for four and a half serial-clock periods, starts an external successive-approximation core and waits for its completion handshake. After that it shifts the signed result back out on falling serial-clock edges, least significant bit first and the sign bit last.

All logic runs on one system clock that oversamples the serial pins through a synchronizer. The data-out and status pins come with separate enable outputs, so the pad ring can tri-state them whenever chip select is high. Raising chip select during a conversion or partway through the readout parks the result until chip select returns low. A power-down pin or an address with the power flag clear shuts the analog section off. Power-up is gated by a parameterised delay during which chip select must stay high.

Top module: `sadc_front`

## Requirements
- R1: With chip select low, five address bits are taken on successive serial-clock rising edges. In arrival order the bits are: power flag (1 = on), mode flag (1 = single-ended, 0 = differential), odd/sign bit, select1, select0.
- R2: Single-ended mode: `mux_pos` = {select1, select0, odd/sign}, `mux_neg_com` = 1 and `mux_neg` = 0.
- R3: Differential mode: `mux_pos` = {select1, select0, odd/sign}, `mux_neg` = {select1, select0, inverted odd/sign} and `mux_neg_com` = 0. The two inputs are always even/odd neighbours.
- R4: `acq` is high from the address decode until the ninth serial-clock edge (rising or falling) after the fifth address rise. That ninth edge fires a one-cycle `sar_start`. `busy` is high from `sar_start` until `sar_done` is seen.
- R5: With chip select low, the first falling serial-clock edge after the result is captured puts result bit 0 on `sdo`. Each later falling edge puts out the next bit, up to bit RES_W-1 (the sign bit), which then stays on `sdo`.
- R6: While chip select is high, falling edges do not advance the readout and the captured result is kept without time limit. Readout resumes at the next unsent bit once chip select is low again.
- R7: `sdo_oe` and `busy_oe` are low while chip select is high and high while it is low.
- R8: After a readout, no new address is accepted until chip select has been seen high on a serial-clock rising edge. Bits clocked in before that cause no conversion.
- R9: An address with the power flag clear turns `analog_on` off and starts no conversion; its other bits are ignored. A later address with the flag set turns `analog_on` on and enters the power-up wait.
- R10: While `pd_pin` is high, `analog_on` is low and no conversion starts. After `pd_pin` falls, chip select must stay high for PUP_CLKS consecutive system clocks before an address is accepted. An address sent earlier is ignored.
- R11: `res_valid` is 0 for the first conversion after reset and 1 for every later conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock from host |
| sdi | input | 1 | Serial address input |
| pd_pin | input | 1 | Hardware power-down, active high |
| sdo | output | 1 | Serial result output |
| sdo_oe | output | 1 | Output enable for sdo |
| busy | output | 1 | Conversion in progress |
| busy_oe | output | 1 | Output enable for busy |
| analog_on | output | 1 | Analog section powered |
| acq | output | 1 | Acquisition window active |
| mux_en | output | 1 | Multiplexer inputs connected |
| mux_pos | output | 3 | Positive input channel index |
| mux_neg | output | 3 | Negative input channel index (differential) |
| mux_neg_com | output | 1 | Negative input is the common pin |
| sar_start | output | 1 | One-cycle start to converter core |
| sar_done | input | 1 | Core completion pulse |
| sar_result | input | RES_W | Signed core result, sign in top bit |
| res_valid | output | 1 | Captured result is trustworthy |

## Verification
The bench builds the block with an 11-bit result, a 9-edge acquisition window and a power-up wait of 40 system clocks. The short wait lets a test attempt a premature address and still reach a later valid conversion in a few hundred cycles. Serial-clock half periods of eight system clocks give enough margin that each falling-edge bit and each start pulse can be sampled in a known cycle. Random addresses, random results and three chip-select patterns (held low, raised during conversion, raised mid-readout) cover both multiplexer modes and the parking behaviour.

// File: rtl/sadc_pkg.sv
package sadc_pkg;
  localparam int ADDR_W = 5;
  localparam int CH_W   = 3;

  typedef enum logic [2:0] {
    ST_HOLD, ST_IDLE, ST_SHIFT, ST_ACQ, ST_CONV, ST_SEND, ST_WAKE
  } st_t;

  typedef struct packed {
    logic            pu;
    logic            single;
    logic [CH_W-1:0] pos;
    logic [CH_W-1:0] neg;
  } sel_t;
endpackage

// File: rtl/sadc_sync_edge.sv
module sadc_sync_edge #(
  parameter int          STAGES  = 2,
  parameter int          W       = 4,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         rise0,
  output logic         fall0
);
  logic [W-1:0] chain [STAGES];
  logic         prev0;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= RST_VAL;
          else     chain[g] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= RST_VAL;
          else     chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev0 <= RST_VAL[0];
    else     prev0 <= chain[STAGES-1][0];
  end

  assign dout  = chain[STAGES-1];
  assign rise0 = dout[0] & ~prev0;
  assign fall0 = ~dout[0] & prev0;
endmodule

// File: rtl/sadc_addr_dec.sv
module sadc_addr_dec
  import sadc_pkg::*;
(
  input  logic [ADDR_W-1:0] word,
  output sel_t              sel
);
  // arrival order: word[4] first .. word[0] last
  always_comb begin
    sel.pu     = word[4];
    sel.single = word[3];
    sel.pos    = {word[1], word[0], word[2]};
    sel.neg    = word[3] ? '0 : {word[1], word[0], ~word[2]};
  end
endmodule

// File: rtl/sadc_pwr_wait.sv
module sadc_pwr_wait #(
  parameter int PUP_CLKS = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic done
);
  localparam int CW = $clog2(PUP_CLKS + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !en) cnt <= '0;
    else if (cnt != CW'(PUP_CLKS - 1)) cnt <= cnt + 1'b1;
  end

  assign done = en && (cnt == CW'(PUP_CLKS - 1));
endmodule

// File: rtl/sadc_front.sv
module sadc_front
  import sadc_pkg::*;
#(
  parameter int RES_W       = 11,
  parameter int ACQ_EDGES   = 9,
  parameter int PUP_CLKS    = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cs_n,
  input  logic             sclk,
  input  logic             sdi,
  input  logic             pd_pin,
  output logic             sdo,
  output logic             sdo_oe,
  output logic             busy,
  output logic             busy_oe,
  output logic             analog_on,
  output logic             acq,
  output logic             mux_en,
  output logic [CH_W-1:0]  mux_pos,
  output logic [CH_W-1:0]  mux_neg,
  output logic             mux_neg_com,
  output logic             sar_start,
  input  logic             sar_done,
  input  logic [RES_W-1:0] sar_result,
  output logic             res_valid
);
  localparam int BIT_CW = $clog2(RES_W);
  localparam int ACQ_CW = $clog2(ACQ_EDGES);
  localparam int ADR_CW = $clog2(ADDR_W);

  logic [3:0] pins_s;
  logic       rise, fall;
  logic       cs_lo, sdi_s, pd_s;

  sadc_sync_edge #(.STAGES(SYNC_STAGES), .W(4), .RST_VAL(4'b0010)) u_sync (
    .clk(clk), .rst(rst),
    .din({pd_pin, sdi, cs_n, sclk}),
    .dout(pins_s), .rise0(rise), .fall0(fall)
  );
  assign cs_lo = ~pins_s[1];
  assign sdi_s = pins_s[2];
  assign pd_s  = pins_s[3];

  st_t               state;
  logic [ADDR_W-1:0] addr;
  logic [ADR_CW-1:0] abit;
  logic [ACQ_CW-1:0] acq_cnt;
  logic [BIT_CW-1:0] bit_cnt;
  logic [RES_W-1:0]  res_q;
  logic              pwr_on, seen, oe_q;
  sel_t              sel_new, sel_q;
  logic              wake_en, wake_done;

  sadc_addr_dec u_dec (.word({addr[ADDR_W-2:0], sdi_s}), .sel(sel_new));

  assign wake_en = (state == ST_WAKE) && !cs_lo && !pd_s;
  sadc_pwr_wait #(.PUP_CLKS(PUP_CLKS)) u_pwr (
    .clk(clk), .rst(rst), .en(wake_en), .done(wake_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_HOLD;
      addr      <= '0;
      abit      <= '0;
      acq_cnt   <= '0;
      bit_cnt   <= '0;
      res_q     <= '0;
      sel_q     <= '0;
      pwr_on    <= 1'b1;
      seen      <= 1'b0;
      res_valid <= 1'b0;
      sar_start <= 1'b0;
      busy      <= 1'b0;
      sdo       <= 1'b0;
      oe_q      <= 1'b0;
    end else begin
      sar_start <= 1'b0;
      oe_q      <= cs_lo;
      if (pd_s) begin
        state  <= ST_WAKE;
        pwr_on <= 1'b0;
        busy   <= 1'b0;
      end else begin
        case (state)
          ST_HOLD: if (rise && !cs_lo) state <= ST_IDLE;
          ST_IDLE: if (cs_lo) begin
            state <= ST_SHIFT;
            abit  <= '0;
          end
          ST_SHIFT: begin
            if (!cs_lo) state <= ST_IDLE;
            else if (rise) begin
              addr <= {addr[ADDR_W-2:0], sdi_s};
              abit <= abit + 1'b1;
              if (abit == ADR_CW'(ADDR_W - 1)) begin
                if (!sel_new.pu) begin
                  pwr_on <= 1'b0;
                  state  <= ST_HOLD;
                end else if (!pwr_on) begin
                  pwr_on <= 1'b1;
                  state  <= ST_WAKE;
                end else begin
                  sel_q   <= sel_new;
                  acq_cnt <= '0;
                  state   <= ST_ACQ;
                end
              end
            end
          end
          ST_ACQ: if (rise || fall) begin
            acq_cnt <= acq_cnt + 1'b1;
            if (acq_cnt == ACQ_CW'(ACQ_EDGES - 1)) begin
              sar_start <= 1'b1;
              busy      <= 1'b1;
              state     <= ST_CONV;
            end
          end
          ST_CONV: if (sar_done) begin
            res_q     <= sar_result;
            res_valid <= seen;
            seen      <= 1'b1;
            busy      <= 1'b0;
            bit_cnt   <= '0;
            state     <= ST_SEND;
          end
          ST_SEND: if (cs_lo && fall) begin
            sdo     <= res_q[bit_cnt];
            bit_cnt <= bit_cnt + 1'b1;
            if (bit_cnt == BIT_CW'(RES_W - 1)) state <= ST_HOLD;
          end
          ST_WAKE: if (wake_done) begin
            pwr_on <= 1'b1;
            state  <= ST_IDLE;
          end
          default: state <= ST_HOLD;
        endcase
      end
    end
  end

  assign sdo_oe      = oe_q;
  assign busy_oe     = oe_q;
  assign analog_on   = pwr_on;
  assign acq         = (state == ST_ACQ);
  assign mux_en      = (state == ST_ACQ) || (state == ST_CONV);
  assign mux_pos     = sel_q.pos;
  assign mux_neg     = sel_q.neg;
  assign mux_neg_com = sel_q.single;
endmodule

// File: rtl/sadc_front_chk.sv
module sadc_front_chk #(
  parameter int CH_W = 3
) (
  input logic            clk,
  input logic            rst,
  input logic            sar_start,
  input logic            sar_done,
  input logic            busy,
  input logic            pd_s,
  input logic            analog_on,
  input logic            mux_en,
  input logic [CH_W-1:0] mux_pos,
  input logic [CH_W-1:0] mux_neg,
  input logic            mux_neg_com
);
  // R4
  start_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    sar_start |=> !sar_start);
  // R4
  start_busy_chk: assert property (@(posedge clk) disable iff (rst)
    sar_start |-> busy);
  // R4
  busy_end_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> ($past(sar_done) || $past(pd_s)));
  // R10
  start_powered_chk: assert property (@(posedge clk) disable iff (rst)
    sar_start |-> analog_on);
  // R9
  mux_powered_chk: assert property (@(posedge clk) disable iff (rst)
    mux_en |-> analog_on);
  // R3
  pair_chk: assert property (@(posedge clk) disable iff (rst)
    (mux_en && !mux_neg_com) |->
      (mux_pos[CH_W-1:1] == mux_neg[CH_W-1:1] && mux_pos[0] != mux_neg[0]));
endmodule

bind sadc_front sadc_front_chk #(.CH_W(sadc_pkg::CH_W)) u_chk (
  .clk(clk), .rst(rst), .sar_start(sar_start), .sar_done(sar_done),
  .busy(busy), .pd_s(pd_s), .analog_on(analog_on), .mux_en(mux_en),
  .mux_pos(mux_pos), .mux_neg(mux_neg), .mux_neg_com(mux_neg_com)
);

// File: tb/sadc_front_bench.sv
module sadc_front_bench;
  localparam int CLK_PERIOD = 10;
  localparam int RES_W      = 11;
  localparam int PUP        = 40;
  localparam int HALF       = 8;
  localparam int SAR_LAT    = 10;

  logic clk = 0, rst = 1;
  logic cs_n = 1, sclk = 0, sdi = 0, pd_pin = 0;
  logic sdo, sdo_oe, busy, busy_oe, analog_on, acq, mux_en, mux_neg_com;
  logic [2:0] mux_pos, mux_neg;
  logic sar_start, sar_done = 0, res_valid;
  logic [RES_W-1:0] sar_result = '0;

  int checks = 0, failures = 0, n_start = 0, lat = 0;
  bit first_done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sadc_front #(.RES_W(RES_W), .ACQ_EDGES(9), .PUP_CLKS(PUP)) u_sadc_front (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .sdi(sdi), .pd_pin(pd_pin),
    .sdo(sdo), .sdo_oe(sdo_oe), .busy(busy), .busy_oe(busy_oe),
    .analog_on(analog_on), .acq(acq), .mux_en(mux_en), .mux_pos(mux_pos),
    .mux_neg(mux_neg), .mux_neg_com(mux_neg_com), .sar_start(sar_start),
    .sar_done(sar_done), .sar_result(sar_result), .res_valid(res_valid)
  );

  // converter core model
  always @(posedge clk) begin
    sar_done <= 1'b0;
    if (sar_start) begin
      n_start <= n_start + 1;
      lat     <= SAR_LAT;
    end else if (lat == 1) begin
      sar_done <= 1'b1;
      lat      <= 0;
    end else if (lat > 0) lat <= lat - 1;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sclk_cycle();
    sclk = 1; waitc(HALF);
    sclk = 0; waitc(HALF);
  endtask

  task automatic arm();
    cs_n = 1; waitc(HALF);
    sclk_cycle();
  endtask

  task automatic send_addr(input logic [4:0] a);
    cs_n = 0; waitc(HALF);
    for (int i = 4; i >= 0; i--) begin
      sdi = a[i];
      sclk_cycle();
    end
  endtask

  function automatic logic [2:0] exp_pos(input logic [4:0] a);
    return {a[1], a[0], a[2]};
  endfunction
  function automatic logic [2:0] exp_neg(input logic [4:0] a);
    return a[3] ? 3'b000 : {a[1], a[0], ~a[2]};
  endfunction

  // mode 0: cs held low, 1: cs raised during conversion, 2: cs raised mid-readout
  task automatic convert(input logic [4:0] a, input logic [RES_W-1:0] res, input int mode);
    int s0;
    sar_result = res;
    arm();
    send_addr(a);
    check("R1 acq after address", acq, 1);
    if (a[3]) begin
      check("R2 pos", mux_pos, exp_pos(a));
      check("R2 neg_com", mux_neg_com, 1);
      check("R2 neg", mux_neg, 0);
    end else begin
      check("R3 pos", mux_pos, exp_pos(a));
      check("R3 neg_com", mux_neg_com, 0);
      check("R3 neg", mux_neg, exp_neg(a));
    end
    s0 = n_start;
    repeat (3) sclk_cycle();
    check("R4 no start at edge 7", n_start, s0);
    sclk = 1; waitc(HALF);
    check("R4 no start at edge 8", n_start, s0);
    check("R4 acq still high", acq, 1);
    sclk = 0; waitc(HALF);
    check("R4 start at edge 9", n_start, s0 + 1);
    check("R4 busy during conversion", busy, 1);
    if (mode == 1) cs_n = 1;
    waitc(20);
    check("R4 busy cleared", busy, 0);
    check("R11 res_valid", res_valid, first_done);
    first_done = 1;
    if (mode == 1) begin
      check("R7 sdo_oe with cs high", sdo_oe, 0);
      check("R7 busy_oe with cs high", busy_oe, 0);
      repeat (2) sclk_cycle();
      waitc(40);
      cs_n = 0; waitc(HALF);
      check("R7 sdo_oe with cs low", sdo_oe, 1);
    end
    for (int i = 0; i < RES_W; i++) begin
      sclk_cycle();
      check(mode == 1 ? "R6 bit after hold" : "R5 result bit", sdo, res[i]);
      if (mode == 2 && i == 3) begin
        cs_n = 1; waitc(HALF);
        repeat (3) sclk_cycle();
        check("R6 bit parked", sdo, res[3]);
        cs_n = 0; waitc(HALF);
      end
    end
    sclk_cycle();
    check("R5 sign bit stays", sdo, res[RES_W-1]);
  endtask

  initial begin
    int s0;
    logic [4:0] a;
    void'($urandom(32'd1234));
    waitc(5);
    check("R7 reset oe", sdo_oe, 0);
    check("R4 reset busy", busy, 0);
    check("R4 reset acq", acq, 0);
    check("R9 reset analog_on", analog_on, 1);
    check("R11 reset res_valid", res_valid, 0);
    rst = 0;
    waitc(5);

    // directed: first conversion after reset is flagged, both modes
    convert(5'b11101, 11'h4A5, 0);
    convert(5'b10110, 11'h3C1, 0);
    convert(5'b10011, 11'h7FF, 1);
    convert(5'b11000, 11'h001, 2);

    // R8: no re-arm, cs stays low
    s0 = n_start;
    send_addr(5'b11010);
    check("R8 no acq without re-arm", acq, 0);
    repeat (4) sclk_cycle();
    check("R8 no start without re-arm", n_start, s0);

    // R9: software power down then up
    arm();
    send_addr(5'b01011);
    waitc(4);
    check("R9 analog off", analog_on, 0);
    check("R9 no acq", acq, 0);
    repeat (4) sclk_cycle();
    check("R9 no start", n_start, s0);
    arm();
    send_addr(5'b11010);
    check("R9 analog on again", analog_on, 1);
    repeat (4) sclk_cycle();
    check("R9 wake address no start", n_start, s0);
    cs_n = 1; waitc(PUP + 10);
    convert(5'b10100, 11'h555, 0);

    // R10: hardware power down, premature address ignored
    pd_pin = 1; waitc(10);
    check("R10 analog off", analog_on, 0);
    pd_pin = 0; waitc(5);
    s0 = n_start;
    arm();
    send_addr(5'b11111);
    repeat (4) sclk_cycle();
    check("R10 early address ignored", n_start, s0);
    check("R10 analog still off", analog_on, 0);
    cs_n = 1; waitc(PUP + 10);
    check("R10 analog on after wait", analog_on, 1);
    convert(5'b11111, 11'h2AA, 0);

    // random
    for (int k = 0; k < 16; k++) begin
      a = {1'b1, 4'($urandom)};
      convert(a, RES_W'($urandom), int'($urandom % 3));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule